// File: doc/BRIEF.md
# Issue Queue Thread Entry Partitioner

This block sits beside a shared issue queue in a processor that runs several hardware threads. It tracks how many queue entries each thread holds and how many entries are still free overall. It gives each thread a cap on the entries it may hold, and it raises a per-thread full flag and a global full flag. The storage and the selection logic of the queue live elsewhere. This block only counts entries and decides whether an insert is allowed.

A static parameter selects one of three sharing modes. In dynamic mode, any thread may use the whole queue. In equal-split mode, the entries are divided evenly among the threads. In threshold mode, each thread is limited to a fixed percentage of the queue. In equal-split and threshold modes, the caps are recomputed whenever the set of active threads changes. Each cycle the block takes at most one insert request, tagged with a thread number. It also takes per-thread release strobes (an entry was freed at commit) and per-thread squash strobes (an entry was flushed). Each of those strobes frees one entry of its thread.

Top module: `iqp_partitioner`

## Requirements
- R1: After reset, every thread count is zero and the global free count equals NUM_ENTRIES. Each cap starts at a mode-dependent value: NUM_ENTRIES in dynamic mode (MODE 0), NUM_ENTRIES / NUM_THREADS truncated in equal-split mode (MODE 1), and THRESH_PCT * NUM_ENTRIES / 100 truncated in threshold mode (MODE 2). With no entries held, each thread's free output therefore equals its cap.
- R2: In dynamic mode, every cap stays at NUM_ENTRIES whatever the active mask does.
- R3: In equal-split mode, a change of `activeMask` with k set bits (k > 0) sets the cap of each active thread to NUM_ENTRIES / k, truncated. Inactive threads keep their caps. A change to an all-zero mask leaves every cap unchanged. The new caps show from the cycle after the edge at which the changed mask is sampled.
- R4: In threshold mode, a change of `activeMask` to exactly one set bit sets that thread's cap to NUM_ENTRIES. Any other mask change leaves every cap unchanged.
- R5: `threadFree` field t (bits t*CNT_W and up) equals the thread's cap minus its count, or zero if the count is not below the cap. `threadFull[t]` is high exactly when that field is zero.
- R6: An accepted insert adds one to the thread's count and takes one from the global free count, both from the next cycle. `insertAccepted` is high in the same cycle as the accepted request.
- R7: An insert is rejected when its thread is full or the queue is globally full. `insertAccepted` is then low, and no count changes because of that insert.
- R8: A release strobe and a squash strobe each remove one entry from their thread, so both together remove two. The count never goes below zero, and strobes on a thread with no entries are ignored. The global free count rises by the number of entries actually removed.
- R9: `globalFull` is high exactly when the global free count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| activeMask | input | NUM_THREADS | One bit per thread that is currently running |
| insertValid | input | 1 | Insert request this cycle |
| insertTid | input | TID_W | Thread number of the insert request |
| releaseStb | input | NUM_THREADS | Per-thread: one entry freed at commit |
| squashStb | input | NUM_THREADS | Per-thread: one entry flushed |
| insertAccepted | output | 1 | The insert request of this cycle is taken |
| threadFull | output | NUM_THREADS | Per-thread full flag |
| threadFree | output | NUM_THREADS*CNT_W | Per-thread free entries, packed by thread |
| globalFull | output | 1 | No free entries in the queue |

## Verification
The bench builds three copies of the block side by side: one for each sharing mode, all with 4 threads, 32 entries and a 50 percent threshold. All three see the same stimulus, so the bench can compare how the modes react to the same mask changes. With 4 threads and 32 entries, a three-thread mask gives the truncated share of 10, and caps can shrink below a thread's current count. The dynamic copy can run the global free count down to zero while its per-thread caps still allow more inserts, which exercises the global-full rejection on its own.

// File: rtl/iqp_pkg.sv
package iqp_pkg;

  typedef enum logic [1:0] {
    SHARE_DYNAMIC   = 2'd0,
    SHARE_EQUAL     = 2'd1,
    SHARE_THRESHOLD = 2'd2
  } share_mode_e;

  // per-thread counter strobes issued by the control to the datapath
  typedef struct packed {
    logic inc;
    logic rel;
    logic sq;
  } thr_strobe_t;

endpackage

// File: rtl/iqp_cap_policy.sv
module iqp_cap_policy
  import iqp_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned CNT_W       = 6,
  parameter share_mode_e MODE        = SHARE_DYNAMIC,
  parameter int unsigned THRESH_PCT  = 50
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_THREADS-1:0]       activeMask,
  output logic [NUM_THREADS*CNT_W-1:0] capVec
);

  localparam int unsigned PCT_CLAMP = (THRESH_PCT > 100) ? 100 : THRESH_PCT;
  localparam int unsigned INIT_CAP =
    (MODE == SHARE_EQUAL)     ? NUM_ENTRIES / NUM_THREADS :
    (MODE == SHARE_THRESHOLD) ? (PCT_CLAMP * NUM_ENTRIES) / 100 :
                                NUM_ENTRIES;

  logic [NUM_THREADS-1:0] maskQ;
  logic [CNT_W-1:0]       capQ [NUM_THREADS];
  logic [CNT_W-1:0]       shareLut [NUM_THREADS+1];
  logic                   maskChanged;
  int                     activeCnt;

  always_comb begin
    shareLut[0] = '0;
    for (int k = 1; k <= NUM_THREADS; k++) begin
      shareLut[k] = CNT_W'(NUM_ENTRIES / k);
    end
  end

  always_comb begin
    activeCnt = 0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      activeCnt = activeCnt + int'(activeMask[t]);
    end
  end

  assign maskChanged = (activeMask != maskQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ <= '1;
      for (int t = 0; t < NUM_THREADS; t++) capQ[t] <= CNT_W'(INIT_CAP);
    end else begin
      maskQ <= activeMask;
      if (maskChanged) begin
        for (int t = 0; t < NUM_THREADS; t++) begin
          unique case (MODE)
            SHARE_EQUAL: begin
              if (activeCnt != 0 && activeMask[t]) capQ[t] <= shareLut[activeCnt];
            end
            SHARE_THRESHOLD: begin
              if (activeCnt == 1 && activeMask[t]) capQ[t] <= CNT_W'(NUM_ENTRIES);
            end
            default: capQ[t] <= CNT_W'(NUM_ENTRIES);
          endcase
        end
      end
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_cap
    assign capVec[t*CNT_W +: CNT_W] = capQ[t];

    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
      int'(capQ[t]) <= int'(NUM_ENTRIES)); // R1

    if (MODE == SHARE_DYNAMIC) begin : g_dyn
      AST_DYN_CAP_FULL: assert property (@(posedge clk) disable iff (!rstN)
        $past(maskChanged) |-> int'(capQ[t]) == int'(NUM_ENTRIES)); // R2
    end else if (MODE == SHARE_EQUAL) begin : g_eq
      AST_EQUAL_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
        (maskChanged && activeCnt != 0 && activeMask[t])
          |=> int'(capQ[t]) == int'(NUM_ENTRIES) / $past(activeCnt)); // R3
      AST_EQUAL_IDLE_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (maskChanged && !activeMask[t]) |=> $stable(capQ[t])); // R3
    end else begin : g_thr
      AST_SOLO_GETS_ALL: assert property (@(posedge clk) disable iff (!rstN)
        (maskChanged && activeCnt == 1 && activeMask[t])
          |=> int'(capQ[t]) == int'(NUM_ENTRIES)); // R4
      AST_THR_KEEP: assert property (@(posedge clk) disable iff (!rstN)
        (maskChanged && activeCnt != 1) |=> $stable(capQ[t])); // R4
    end
  end

endmodule

// File: rtl/iqp_ctrl.sv
module iqp_ctrl
  import iqp_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned TID_W       = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   insertValid,
  input  logic [TID_W-1:0]       insertTid,
  input  logic [NUM_THREADS-1:0] releaseStb,
  input  logic [NUM_THREADS-1:0] squashStb,
  input  logic [NUM_THREADS-1:0] threadFull,
  input  logic                   globalFull,
  output logic                   insertAccepted,
  output thr_strobe_t [NUM_THREADS-1:0] strobes
);

  logic tidInRange;
  logic tidFull;
  logic [NUM_THREADS-1:0] incVec;

  assign tidInRange = (int'(insertTid) < int'(NUM_THREADS));

  always_comb begin
    tidFull = 1'b1;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (int'(insertTid) == t) tidFull = threadFull[t];
    end
  end

  assign insertAccepted = insertValid && tidInRange && !tidFull && !globalFull;

  always_comb begin
    for (int t = 0; t < NUM_THREADS; t++) begin
      incVec[t]     = insertAccepted && (int'(insertTid) == t);
      strobes[t].inc = incVec[t];
      strobes[t].rel = releaseStb[t];
      strobes[t].sq  = squashStb[t];
    end
  end

  AST_INC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(incVec)); // R6
  AST_NO_INS_GLOBAL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    globalFull |-> !insertAccepted); // R7
  AST_NO_INS_THREAD_FULL: assert property (@(posedge clk) disable iff (!rstN)
    (|(incVec & threadFull)) == 1'b0); // R7

endmodule

// File: rtl/iqp_counters.sv
module iqp_counters
  import iqp_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned NUM_ENTRIES = 32,
  parameter int unsigned CNT_W       = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  thr_strobe_t [NUM_THREADS-1:0] strobes,
  input  logic [NUM_THREADS*CNT_W-1:0]  capVec,
  output logic [NUM_THREADS*CNT_W-1:0]  threadFree,
  output logic [NUM_THREADS-1:0]        threadFull,
  output logic                          globalFull
);

  logic [CNT_W-1:0] cntQ [NUM_THREADS];
  logic [CNT_W-1:0] cntD [NUM_THREADS];
  logic [CNT_W-1:0] freeQ;
  logic [CNT_W-1:0] freeD;
  int               occSum;

  always_comb begin
    int incTotal;
    int decTotal;
    incTotal = 0;
    decTotal = 0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      int dec;
      dec = int'(strobes[t].rel) + int'(strobes[t].sq);
      if (dec > int'(cntQ[t])) dec = int'(cntQ[t]);
      cntD[t]  = CNT_W'(int'(cntQ[t]) + int'(strobes[t].inc) - dec);
      incTotal = incTotal + int'(strobes[t].inc);
      decTotal = decTotal + dec;
    end
    freeD = CNT_W'(int'(freeQ) + decTotal - incTotal);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      freeQ <= CNT_W'(NUM_ENTRIES);
      for (int t = 0; t < NUM_THREADS; t++) cntQ[t] <= '0;
    end else begin
      freeQ <= freeD;
      for (int t = 0; t < NUM_THREADS; t++) cntQ[t] <= cntD[t];
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_out
    logic [CNT_W-1:0] capT;
    assign capT = capVec[t*CNT_W +: CNT_W];
    assign threadFree[t*CNT_W +: CNT_W] = (capT > cntQ[t]) ? (capT - cntQ[t]) : '0;
    assign threadFull[t] = (capT <= cntQ[t]);

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[t].inc && !strobes[t].rel && !strobes[t].sq) |=> $stable(cntQ[t])); // R7
    AST_DRAIN_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
      (cntQ[t] == '0 && !strobes[t].inc) |=> cntQ[t] == '0); // R8
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[t].inc && !strobes[t].rel && !strobes[t].sq)
        |=> int'(cntQ[t]) == int'($past(cntQ[t])) + 1); // R6
  end

  assign globalFull = (freeQ == '0);

  always_comb begin
    occSum = 0;
    for (int t = 0; t < NUM_THREADS; t++) occSum = occSum + int'(cntQ[t]);
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    int'(freeQ) + occSum == int'(NUM_ENTRIES)); // R8

endmodule

// File: rtl/iqp_partitioner.sv
module iqp_partitioner
  import iqp_pkg::*;
#(
  parameter int unsigned NUM_THREADS = 4,
  parameter int unsigned NUM_ENTRIES = 32,
  parameter share_mode_e MODE        = SHARE_DYNAMIC,
  parameter int unsigned THRESH_PCT  = 50,
  localparam int unsigned TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
  localparam int unsigned CNT_W      = $clog2(NUM_ENTRIES + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_THREADS-1:0]       activeMask,
  input  logic                         insertValid,
  input  logic [TID_W-1:0]             insertTid,
  input  logic [NUM_THREADS-1:0]       releaseStb,
  input  logic [NUM_THREADS-1:0]       squashStb,
  output logic                         insertAccepted,
  output logic [NUM_THREADS-1:0]       threadFull,
  output logic [NUM_THREADS*CNT_W-1:0] threadFree,
  output logic                         globalFull
);

  logic [NUM_THREADS*CNT_W-1:0]  capVec;
  thr_strobe_t [NUM_THREADS-1:0] strobes;

  iqp_cap_policy #(
    .NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W),
    .MODE(MODE), .THRESH_PCT(THRESH_PCT)
  ) u_policy (
    .clk(clk), .rstN(rstN), .activeMask(activeMask), .capVec(capVec)
  );

  iqp_ctrl #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .insertValid(insertValid), .insertTid(insertTid),
    .releaseStb(releaseStb), .squashStb(squashStb),
    .threadFull(threadFull), .globalFull(globalFull),
    .insertAccepted(insertAccepted), .strobes(strobes)
  );

  iqp_counters #(
    .NUM_THREADS(NUM_THREADS), .NUM_ENTRIES(NUM_ENTRIES), .CNT_W(CNT_W)
  ) u_counters (
    .clk(clk), .rstN(rstN), .strobes(strobes), .capVec(capVec),
    .threadFree(threadFree), .threadFull(threadFull), .globalFull(globalFull)
  );

  AST_GLOBAL_FULL_FREE: assert property (@(posedge clk) disable iff (!rstN)
    globalFull |-> !insertAccepted); // R9

endmodule

// File: tb/tb_iqp_partitioner.sv
module tb_iqp_partitioner;
  import iqp_pkg::*;

  localparam int T  = 4;
  localparam int N  = 32;
  localparam int PCT = 50;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [T-1:0] activeMask = '1;
  logic insertValid = 1'b0;
  logic [1:0] insertTid = '0;
  logic [T-1:0] releaseStb = '0;
  logic [T-1:0] squashStb = '0;

  logic          accO  [3];
  logic [T-1:0]  fullO [3];
  logic [T*CW-1:0] freeO [3];
  logic          gFullO [3];

  int nChecks = 0;
  int nFail = 0;

  always #10 clk = ~clk;

  for (genvar m = 0; m < 3; m++) begin : g_mode
    iqp_partitioner #(
      .NUM_THREADS(T), .NUM_ENTRIES(N), .MODE(share_mode_e'(m)), .THRESH_PCT(PCT)
    ) dut (
      .clk(clk), .rstN(rstN), .activeMask(activeMask),
      .insertValid(insertValid), .insertTid(insertTid),
      .releaseStb(releaseStb), .squashStb(squashStb),
      .insertAccepted(accO[m]), .threadFull(fullO[m]),
      .threadFree(freeO[m]), .globalFull(gFullO[m])
    );
  end

  // behavioural reference model
  int mCap [3][T];
  int mCnt [3][T];
  int mGFree [3];
  logic [T-1:0] mPrev;

  function automatic int initCap(int m);
    if (m == 1) return N / T;
    if (m == 2) return (PCT * N) / 100;
    return N;
  endfunction

  function automatic int expFree(int m, int t);
    return (mCap[m][t] > mCnt[m][t]) ? mCap[m][t] - mCnt[m][t] : 0;
  endfunction

  function automatic bit expAcc(int m);
    return insertValid && (mCnt[m][insertTid] < mCap[m][insertTid]) && (mGFree[m] > 0);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mPrev = '1;
      for (int m = 0; m < 3; m++) begin
        mGFree[m] = N;
        for (int t = 0; t < T; t++) begin
          mCap[m][t] = initCap(m);
          mCnt[m][t] = 0;
        end
      end
    end else begin
      bit acc [3];
      for (int m = 0; m < 3; m++) acc[m] = expAcc(m);
      if (activeMask != mPrev) begin
        int pop;
        pop = $countones(activeMask);
        for (int t = 0; t < T; t++) begin
          if (pop > 0 && activeMask[t]) mCap[1][t] = N / pop;
          if (pop == 1 && activeMask[t]) mCap[2][t] = N;
        end
        mPrev = activeMask;
      end
      for (int m = 0; m < 3; m++) begin
        for (int t = 0; t < T; t++) begin
          int d;
          d = int'(releaseStb[t]) + int'(squashStb[t]);
          if (d > mCnt[m][t]) d = mCnt[m][t];
          mCnt[m][t] = mCnt[m][t] - d;
          mGFree[m] = mGFree[m] + d;
        end
        if (acc[m]) begin
          mCnt[m][insertTid] = mCnt[m][insertTid] + 1;
          mGFree[m] = mGFree[m] - 1;
        end
      end
    end
  end

  task automatic chk(string req, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle compare, away from the clock edge
  always @(negedge clk) begin
    #5;
    if (rstN) begin
      for (int m = 0; m < 3; m++) begin
        for (int t = 0; t < T; t++) begin
          chk("R5 free", int'(freeO[m][t*CW +: CW]), expFree(m, t));
          chk("R5 full", int'(fullO[m][t]), int'(expFree(m, t) == 0));
        end
        chk("R9 globalFull", int'(gFullO[m]), int'(mGFree[m] == 0));
        chk("R7 accept", int'(accO[m]), int'(expAcc(m)));
      end
    end
  end

  task automatic cyc(bit iv, int tid, logic [T-1:0] rel, logic [T-1:0] sq);
    @(negedge clk);
    insertValid = iv;
    insertTid = 2'(tid);
    releaseStb = rel;
    squashStb = sq;
    @(posedge clk);
    #1;
    insertValid = 1'b0;
    releaseStb = '0;
    squashStb = '0;
  endtask

  task automatic setMask(logic [T-1:0] mk);
    @(negedge clk);
    activeMask = mk;
    @(posedge clk);
  endtask

  task automatic settle();
    @(negedge clk);
    #5;
  endtask

  function automatic int fr(int m, int t);
    return int'(freeO[m][t*CW +: CW]);
  endfunction

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL R6 watchdog expired actual=1 expected=0");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    settle();
    // R1: reset state per mode
    chk("R1 dyn free", fr(0, 0), 32);
    chk("R1 equal free", fr(1, 3), 8);
    chk("R1 thr free", fr(2, 2), 16);
    chk("R1 globalFull", int'(gFullO[0]), 0);

    for (int i = 0; i < 5; i++) cyc(1, 0, '0, '0);
    settle();
    chk("R6 dyn free", fr(0, 0), 27);
    chk("R6 equal free", fr(1, 0), 3);
    chk("R6 thr free", fr(2, 0), 11);

    for (int i = 0; i < 4; i++) cyc(1, 0, '0, '0);
    settle();
    chk("R7 equal full", int'(fullO[1][0]), 1);
    chk("R7 equal free", fr(1, 0), 0);
    chk("R7 dyn free", fr(0, 0), 23);

    cyc(0, 0, 4'b0001, 4'b0001);
    settle();
    chk("R8 dyn both", fr(0, 0), 25);
    chk("R8 equal both", fr(1, 0), 2);
    chk("R8 thr both", fr(2, 0), 9);

    cyc(0, 0, 4'b1000, 4'b1000);
    settle();
    chk("R8 empty ignored", fr(1, 3), 8);

    setMask(4'b0011);
    settle();
    chk("R3 equal two", fr(1, 0), 10);
    chk("R3 inactive kept", fr(1, 2), 8);
    chk("R4 thr unchanged", fr(2, 0), 9);
    chk("R2 dyn unchanged", fr(0, 0), 25);

    setMask(4'b0001);
    settle();
    chk("R4 thr solo", fr(2, 0), 25);
    chk("R3 equal solo", fr(1, 0), 26);

    setMask(4'b0011);
    settle();
    chk("R4 thr kept", fr(2, 0), 25);

    setMask(4'b0111);
    settle();
    chk("R3 equal three", fr(1, 1), 10);

    setMask(4'b0000);
    settle();
    chk("R3 empty mask", fr(1, 1), 10);

    setMask(4'b1111);
    for (int i = 0; i < 40; i++) cyc(1, 1, '0, '0);
    settle();
    chk("R9 dyn globalFull", int'(gFullO[0]), 1);
    cyc(1, 2, '0, '0);
    settle();
    chk("R7 global reject", fr(0, 2), 32);
    chk("R2 dyn cap", fr(0, 1), 7);

    for (int i = 0; i < 3000; i++) begin
      if (($urandom % 50) == 0) begin
        @(negedge clk);
        activeMask = 4'($urandom);
      end
      cyc(($urandom % 3) != 0, int'($urandom % 4),
          4'($urandom) & 4'($urandom), 4'($urandom) & 4'($urandom) & 4'($urandom));
    end
    for (int i = 0; i < 40; i++) cyc(0, 0, '1, '1);
    settle();
    chk("R8 drained", int'(gFullO[0]), 0);
    finishRun();
  end

endmodule